// File: doc/BRIEF.md
# Register-Linked Hardware Queue Unit

This unit holds a set of hardware-managed single-producer, single-consumer queues that sit between two neighbouring cores. The producer core pushes values into a queue and the consumer core pops them. Each push or pop is also a synchronization point: the issuing core is held while the queue cannot accept or supply a value. Chains of such queues let cores form systolic dataflows with no central controller.

A core can reach a queue in two ways. It can name the queue in an explicit enqueue or dequeue operation. It can also use an ordinary register access. A configuration port binds a register index to a queue. After that, a producer write to the index pushes the value, and a consumer read of the index pops the head, so software never touches pointers. Indices with no binding behave as plain storage held inside the unit.

Stall and read data are combinational from the current state. An operation that is not stalled commits on the next rising clock edge.

Top module: `rlq_unit`

## Requirements
- R1: Synchronous active-high reset has these effects. Every queue reads empty and not full. Every binding is cleared. All plain register storage reads zero. Neither stall output is asserted while both ports are idle.
- R2: Each queue returns entries in exactly the order they were accepted.
- R3: A producer operation that targets a full queue raises `prd_stall` in the same cycle. The value is dropped. The queue contents and the `q_full` flag stay unchanged.
- R4: A consumer operation that targets an empty queue raises `cns_stall` in the same cycle and drives `cns_data` to zero.
- R5: An operation that is not stalled commits at the next rising edge. After an accepted push, the queue's `q_empty` bit is low in the following cycle. After an accepted pop, the queue's `q_full` bit is low in the following cycle.
- R6: When a push and a pop target the same queue in the same cycle, the result depends on the queue state:
  - If the queue is partly filled, both succeed and the occupancy does not change.
  - If the queue is full, the pop succeeds and the push stalls.
  - If the queue is empty, the push succeeds and the pop stalls.
- R7: A producer register write (`prd_explicit`=0) to an index bound to a queue pushes `prd_data` into that queue. A consumer register read (`cns_explicit`=0) of a bound index pops that queue's head onto `cns_data`.
- R8: A register access to an index with no enabled binding never stalls and leaves every queue untouched. A write stores the value. A read returns the last stored value, and a value written in a cycle is visible from the next cycle.
- R9: When several enabled bindings name the same index, the queue with the lowest number serves the access. Explicit operations (`prd_explicit`/`cns_explicit`=1) use `prd_qid`/`cns_qid` directly and ignore all bindings.
- R10: Queues are independent. An operation on one queue neither changes nor stalls on the state of another.
- R11: A configuration write (`cfg_valid`=1) sets queue `cfg_qid`'s binding to index `cfg_reg` with enable `cfg_enable`. The new binding governs accesses from the next cycle onward. Clearing the enable returns the index to plain storage, and that storage still holds the value it had before the binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Binding update strobe |
| cfg_qid | input | $clog2(NUM_Q) | Queue whose binding is updated |
| cfg_enable | input | 1 | New binding enable |
| cfg_reg | input | $clog2(NUM_REG) | Register index bound to the queue |
| prd_valid | input | 1 | Producer request present |
| prd_explicit | input | 1 | 1: explicit enqueue to `prd_qid`; 0: register write to `prd_reg` |
| prd_qid | input | $clog2(NUM_Q) | Queue for explicit enqueue |
| prd_reg | input | $clog2(NUM_REG) | Register index for a register write |
| prd_data | input | DATA_W | Value written or enqueued |
| prd_stall | output | 1 | Producer request cannot complete this cycle |
| cns_valid | input | 1 | Consumer request present |
| cns_explicit | input | 1 | 1: explicit dequeue from `cns_qid`; 0: register read of `cns_reg` |
| cns_qid | input | $clog2(NUM_Q) | Queue for explicit dequeue |
| cns_reg | input | $clog2(NUM_REG) | Register index for a register read |
| cns_data | output | DATA_W | Dequeued head or register value; zero when stalled or idle |
| cns_stall | output | 1 | Consumer request cannot complete this cycle |
| q_full | output | NUM_Q | Per-queue full flag |
| q_empty | output | NUM_Q | Per-queue empty flag |

## Verification
The bench builds the unit with its defaults: four queues of depth four, 16-bit data and eight register indices. A depth of four lets a handful of pushes reach the full state and lets the pointers wrap while the queue is full, so the wrap bit is tested. Four queues allow two bindings to share one index, which exercises the priority rule, while other queues remain idle and serve as independence witnesses. Eight indices leave room for bound and plain indices to be accessed side by side in the same cycle.

// File: rtl/rlq_pkg.sv
package rlq_pkg;

    // Where a producer or consumer request is routed after decode.
    typedef enum logic [1:0] {
        TGT_IDLE  = 2'd0,
        TGT_PLAIN = 2'd1,
        TGT_QUEUE = 2'd2
    } tgt_e;

    localparam int DEF_NUM_Q   = 4;
    localparam int DEF_DEPTH   = 4;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_NUM_REG = 8;

    // Power-of-two test for depth; the wrap-bit pointer scheme relies on it.
    function automatic bit is_pow2(input int v);
        return (v > 1) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rlq_fifo.sv
module rlq_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]       wr_ptr;
    logic [AW:0]       rd_ptr;
    logic [DATA_W-1:0] store [DEPTH];
    logic              do_push;
    logic              do_pop;

    // Pointers equal except the top bit: writer lapped the reader.
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty   = (wr_ptr == rd_ptr);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    assign head_data = store[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr[AW-1:0]] <= push_data;
    end

endmodule

// File: rtl/rlq_bind_map.sv
module rlq_bind_map #(
    parameter int NUM_Q = 4,
    parameter int RW    = 3,
    parameter int QW    = 2
) (
    input  logic [NUM_Q-1:0] bind_en,
    input  logic [RW-1:0]    bind_reg [NUM_Q],
    input  logic [RW-1:0]    reg_idx,
    output logic             hit,
    output logic [QW-1:0]    qid
);
    // Scan from the top so the lowest matching queue is the last writer.
    always_comb begin
        hit = 1'b0;
        qid = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (bind_en[i] && (bind_reg[i] == reg_idx)) begin
                hit = 1'b1;
                qid = QW'(i);
            end
        end
    end

endmodule

// File: rtl/rlq_regfile.sv
module rlq_regfile #(
    parameter int NUM_REG = 8,
    parameter int DATA_W  = 16,
    parameter int RW      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [NUM_REG];

    assign rdata = cells[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REG; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/rlq_unit.sv
module rlq_unit
    import rlq_pkg::*;
#(
    parameter int NUM_Q   = DEF_NUM_Q,
    parameter int DEPTH   = DEF_DEPTH,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int NUM_REG = DEF_NUM_REG,
    localparam int QW     = $clog2(NUM_Q),
    localparam int RW     = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [QW-1:0]     cfg_qid,
    input  logic              cfg_enable,
    input  logic [RW-1:0]     cfg_reg,
    input  logic              prd_valid,
    input  logic              prd_explicit,
    input  logic [QW-1:0]     prd_qid,
    input  logic [RW-1:0]     prd_reg,
    input  logic [DATA_W-1:0] prd_data,
    output logic              prd_stall,
    input  logic              cns_valid,
    input  logic              cns_explicit,
    input  logic [QW-1:0]     cns_qid,
    input  logic [RW-1:0]     cns_reg,
    output logic [DATA_W-1:0] cns_data,
    output logic              cns_stall,
    output logic [NUM_Q-1:0]  q_full,
    output logic [NUM_Q-1:0]  q_empty
);
    typedef struct packed {
        tgt_e          kind;
        logic [QW-1:0] qid;
    } route_t;

    // Binding table: one entry per queue.
    logic [NUM_Q-1:0]  bind_en;
    logic [RW-1:0]     bind_reg [NUM_Q];

    always_ff @(posedge clk) begin
        if (rst) begin
            bind_en <= '0;
            for (int i = 0; i < NUM_Q; i++) bind_reg[i] <= '0;
        end else if (cfg_valid) begin
            bind_en[cfg_qid]  <= cfg_enable;
            bind_reg[cfg_qid] <= cfg_reg;
        end
    end

    // Register-index lookups, one per port.
    logic          p_hit;
    logic [QW-1:0] p_map_q;
    logic          c_hit;
    logic [QW-1:0] c_map_q;

    rlq_bind_map #(.NUM_Q(NUM_Q), .RW(RW), .QW(QW)) u_prd_map (
        .bind_en  (bind_en),
        .bind_reg (bind_reg),
        .reg_idx  (prd_reg),
        .hit      (p_hit),
        .qid      (p_map_q)
    );

    rlq_bind_map #(.NUM_Q(NUM_Q), .RW(RW), .QW(QW)) u_cns_map (
        .bind_en  (bind_en),
        .bind_reg (bind_reg),
        .reg_idx  (cns_reg),
        .hit      (c_hit),
        .qid      (c_map_q)
    );

    // Request routing.
    route_t p_rt;
    route_t c_rt;

    always_comb begin
        p_rt = '{kind: TGT_IDLE, qid: '0};
        if (prd_valid) begin
            if (prd_explicit)  p_rt = '{kind: TGT_QUEUE, qid: prd_qid};
            else if (p_hit)    p_rt = '{kind: TGT_QUEUE, qid: p_map_q};
            else               p_rt = '{kind: TGT_PLAIN, qid: '0};
        end
    end

    always_comb begin
        c_rt = '{kind: TGT_IDLE, qid: '0};
        if (cns_valid) begin
            if (cns_explicit)  c_rt = '{kind: TGT_QUEUE, qid: cns_qid};
            else if (c_hit)    c_rt = '{kind: TGT_QUEUE, qid: c_map_q};
            else               c_rt = '{kind: TGT_PLAIN, qid: '0};
        end
    end

    // Queue array.
    logic [NUM_Q-1:0]  push_vec;
    logic [NUM_Q-1:0]  pop_vec;
    logic [DATA_W-1:0] head_data [NUM_Q];

    assign prd_stall = (p_rt.kind == TGT_QUEUE) && q_full[p_rt.qid];
    assign cns_stall = (c_rt.kind == TGT_QUEUE) && q_empty[c_rt.qid];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        assign push_vec[g] = (p_rt.kind == TGT_QUEUE) && (p_rt.qid == QW'(g)) && !prd_stall;
        assign pop_vec[g]  = (c_rt.kind == TGT_QUEUE) && (c_rt.qid == QW'(g)) && !cns_stall;

        rlq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (push_vec[g]),
            .push_data (prd_data),
            .pop       (pop_vec[g]),
            .head_data (head_data[g]),
            .full      (q_full[g]),
            .empty     (q_empty[g])
        );
    end

    // Plain register storage for unbound indices.
    logic [DATA_W-1:0] rf_rdata;

    rlq_regfile #(.NUM_REG(NUM_REG), .DATA_W(DATA_W), .RW(RW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (p_rt.kind == TGT_PLAIN),
        .waddr (prd_reg),
        .wdata (prd_data),
        .raddr (cns_reg),
        .rdata (rf_rdata)
    );

    always_comb begin
        cns_data = '0;
        unique case (c_rt.kind)
            TGT_QUEUE: if (!cns_stall) cns_data = head_data[c_rt.qid];
            TGT_PLAIN: cns_data = rf_rdata;
            default:   cns_data = '0;
        endcase
    end

endmodule

// File: rtl/rlq_unit_chk.sv
module rlq_unit_chk #(
    parameter int NUM_Q  = 4,
    parameter int DATA_W = 16,
    parameter int QW     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              prd_valid,
    input logic              prd_explicit,
    input logic [QW-1:0]     prd_qid,
    input logic              prd_stall,
    input logic              cns_valid,
    input logic              cns_explicit,
    input logic [QW-1:0]     cns_qid,
    input logic [DATA_W-1:0] cns_data,
    input logic              cns_stall,
    input logic [NUM_Q-1:0]  q_full,
    input logic [NUM_Q-1:0]  q_empty
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ((&q_empty) && (q_full == '0)));

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (prd_valid && prd_explicit && q_full[prd_qid]) |-> prd_stall);

    // R3
    no_full_empty_chk: assert property (@(posedge clk) disable iff (rst)
        ((q_full & q_empty) == '0));

    // R4
    empty_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (cns_valid && cns_explicit && q_empty[cns_qid]) |-> cns_stall);

    // R4
    stall_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        cns_stall |-> (cns_data == '0));

    // R5
    push_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (prd_valid && prd_explicit && !prd_stall) |=> !q_empty[$past(prd_qid)]);

    // R5
    pop_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (cns_valid && cns_explicit && !cns_stall) |=> !q_full[$past(cns_qid)]);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!prd_valid && !cns_valid) |=> ($stable(q_full) && $stable(q_empty)));

endmodule

bind rlq_unit rlq_unit_chk #(.NUM_Q(NUM_Q), .DATA_W(DATA_W), .QW(QW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .prd_valid    (prd_valid),
    .prd_explicit (prd_explicit),
    .prd_qid      (prd_qid),
    .prd_stall    (prd_stall),
    .cns_valid    (cns_valid),
    .cns_explicit (cns_explicit),
    .cns_qid      (cns_qid),
    .cns_data     (cns_data),
    .cns_stall    (cns_stall),
    .q_full       (q_full),
    .q_empty      (q_empty)
);

// File: tb/rlq_unit_test.sv
module rlq_unit_test;
    localparam int NQ = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_valid = 0;
    logic [1:0]    cfg_qid = 0;
    logic          cfg_enable = 0;
    logic [2:0]    cfg_reg = 0;
    logic          prd_valid = 0;
    logic          prd_explicit = 0;
    logic [1:0]    prd_qid = 0;
    logic [2:0]    prd_reg = 0;
    logic [DW-1:0] prd_data = 0;
    logic          prd_stall;
    logic          cns_valid = 0;
    logic          cns_explicit = 0;
    logic [1:0]    cns_qid = 0;
    logic [2:0]    cns_reg = 0;
    logic [DW-1:0] cns_data;
    logic          cns_stall;
    logic [NQ-1:0] q_full;
    logic [NQ-1:0] q_empty;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rlq_unit uut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_qid(cfg_qid), .cfg_enable(cfg_enable), .cfg_reg(cfg_reg),
        .prd_valid(prd_valid), .prd_explicit(prd_explicit), .prd_qid(prd_qid),
        .prd_reg(prd_reg), .prd_data(prd_data), .prd_stall(prd_stall),
        .cns_valid(cns_valid), .cns_explicit(cns_explicit), .cns_qid(cns_qid),
        .cns_reg(cns_reg), .cns_data(cns_data), .cns_stall(cns_stall),
        .q_full(q_full), .q_empty(q_empty)
    );

    typedef struct packed {
        logic          cv; logic [1:0] cq; logic ce; logic [2:0] cr;
        logic          pv; logic px; logic [1:0] pq; logic [2:0] pr; logic [15:0] pd;
        logic          nv; logic nx; logic [1:0] nq; logic [2:0] nr;
        logic          eps; logic ecs; logic [15:0] ecd;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 33;
    // cfg | producer | consumer | expected stall_p, stall_c, data | requirement number
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0, 1,1,0,0,16'h0011, 0,0,0,0, 0,0,16'h0000, 8'd2},  // R2 push q0
        '{0,0,0,0, 1,1,0,0,16'h0022, 0,0,0,0, 0,0,16'h0000, 8'd2},  // R2
        '{0,0,0,0, 1,1,0,0,16'h0033, 1,1,0,0, 0,0,16'h0011, 8'd6},  // R6 partial both
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,0,0, 0,0,16'h0022, 8'd2},  // R2 order
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,0,0, 0,0,16'h0033, 8'd2},  // R2
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,0,0, 0,1,16'h0000, 8'd4},  // R4 empty pop
        '{0,0,0,0, 1,1,0,0,16'h0044, 1,1,0,0, 0,1,16'h0000, 8'd6},  // R6 empty: pop stalls
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,0,0, 0,0,16'h0044, 8'd6},  // R6 push landed
        '{0,0,0,0, 1,1,1,0,16'h0001, 1,1,0,0, 0,1,16'h0000, 8'd10}, // R10 q1 push, q0 empty
        '{0,0,0,0, 1,1,1,0,16'h0002, 0,0,0,0, 0,0,16'h0000, 8'd2},
        '{0,0,0,0, 1,1,1,0,16'h0003, 0,0,0,0, 0,0,16'h0000, 8'd2},
        '{0,0,0,0, 1,1,1,0,16'h0004, 0,0,0,0, 0,0,16'h0000, 8'd2},
        '{0,0,0,0, 1,1,1,0,16'h0005, 0,0,0,0, 1,0,16'h0000, 8'd3},  // R3 full push
        '{0,0,0,0, 1,1,1,0,16'h0006, 1,1,1,0, 1,0,16'h0001, 8'd6},  // R6 full: push stalls
        '{0,0,0,0, 1,1,1,0,16'h0007, 0,0,0,0, 0,0,16'h0000, 8'd3},  // R3 space again, wrap
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,1,0, 0,0,16'h0002, 8'd2},
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,1,0, 0,0,16'h0003, 8'd2},
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,1,0, 0,0,16'h0004, 8'd2},
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,1,0, 0,0,16'h0007, 8'd3},  // R3 dropped values absent
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,1,0, 0,1,16'h0000, 8'd4},  // R4
        '{1,2,1,5, 1,0,0,3,16'h00AB, 1,0,0,3, 0,0,16'h0000, 8'd8},  // R8 plain write, bind q2->5
        '{0,0,0,0, 1,0,0,5,16'h0055, 1,0,0,3, 0,0,16'h00AB, 8'd8},  // R8 plain read; R7 push
        '{1,3,1,5, 1,0,0,5,16'h0066, 1,0,0,5, 0,0,16'h0055, 8'd7},  // R7 linked read/write
        '{0,0,0,0, 1,0,0,5,16'h0077, 1,1,3,0, 0,1,16'h0000, 8'd9},  // R9 q2 wins, q3 empty
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,0,0,5, 0,0,16'h0066, 8'd7},  // R7
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,0,0,5, 0,0,16'h0077, 8'd9},  // R9
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,0,0,5, 0,1,16'h0000, 8'd4},  // R4 linked empty
        '{1,2,0,5, 0,0,0,0,16'h0000, 1,0,0,5, 0,1,16'h0000, 8'd11}, // R11 unbind not yet active
        '{1,3,0,5, 1,0,0,5,16'h0088, 0,0,0,0, 0,0,16'h0000, 8'd11}, // R11 q3 now serves 5
        '{0,0,0,0, 1,0,0,5,16'h0099, 1,1,3,0, 0,0,16'h0088, 8'd11}, // R11 5 plain again
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,0,0,5, 0,0,16'h0099, 8'd8},  // R8
        '{0,0,0,0, 1,1,2,0,16'h00EE, 1,0,0,5, 0,0,16'h0099, 8'd9},  // R9 explicit ignores map
        '{0,0,0,0, 0,0,0,0,16'h0000, 1,1,2,0, 0,0,16'h00EE, 8'd9}   // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_valid = 0; prd_valid = 0; cns_valid = 0;
        prd_explicit = 0; cns_explicit = 0;
    endtask

    task automatic push_q(input logic [1:0] q, input logic [15:0] d);
        @(negedge clk);
        idle();
        prd_valid = 1; prd_explicit = 1; prd_qid = q; prd_data = d;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        // R1: state after reset
        #1;
        check("R1 empty flags", 32'(q_empty), 32'hF);
        check("R1 full flags", 32'(q_full), 32'h0);
        check("R1 idle producer stall", 32'(prd_stall), 32'h0);
        check("R1 idle consumer stall", 32'(cns_stall), 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_valid = VECS[i].cv; cfg_qid = VECS[i].cq;
            cfg_enable = VECS[i].ce; cfg_reg = VECS[i].cr;
            prd_valid = VECS[i].pv; prd_explicit = VECS[i].px;
            prd_qid = VECS[i].pq; prd_reg = VECS[i].pr; prd_data = VECS[i].pd;
            cns_valid = VECS[i].nv; cns_explicit = VECS[i].nx;
            cns_qid = VECS[i].nq; cns_reg = VECS[i].nr;
            #1;
            n_run++;
            if (prd_stall !== VECS[i].eps || cns_stall !== VECS[i].ecs || cns_data !== VECS[i].ecd) begin
                n_fail++;
                $display("FAIL R%0d row %0d: actual ps=%b cs=%b d=%h expected ps=%b cs=%b d=%h",
                         VECS[i].req, i, prd_stall, cns_stall, cns_data,
                         VECS[i].eps, VECS[i].ecs, VECS[i].ecd);
            end
        end

        // R5: empty flag drops the cycle after an accepted push
        push_q(2'd1, 16'h0A0A);
        #1;
        check("R5 empty before edge", 32'(q_empty[1]), 32'h1);
        @(negedge clk);
        idle();
        #1;
        check("R5 empty after edge", 32'(q_empty[1]), 32'h0);
        check("R10 other queues empty", 32'(q_empty & 4'b1101), 32'hD);
        push_q(2'd1, 16'h0B0B);
        push_q(2'd1, 16'h0C0C);
        push_q(2'd1, 16'h0D0D);
        #1;
        check("R5 full before edge", 32'(q_full[1]), 32'h0);
        @(negedge clk);
        idle();
        #1;
        check("R3 full flag", 32'(q_full), 32'h2);
        prd_valid = 1; prd_explicit = 1; prd_qid = 2'd1; prd_data = 16'hFFFF;
        #1;
        check("R3 stall on full", 32'(prd_stall), 32'h1);
        @(negedge clk);
        idle();
        cns_valid = 1; cns_explicit = 1; cns_qid = 2'd1;
        #1;
        check("R2 head after full", 32'(cns_data), 32'h0A0A);
        @(negedge clk);
        idle();
        #1;
        check("R5 full drops after pop", 32'(q_full[1]), 32'h0);

        // R1: reset mid-run clears queues, bindings and storage
        @(negedge clk);
        cfg_valid = 1; cfg_qid = 2'd0; cfg_enable = 1; cfg_reg = 3'd6;
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        check("R1 empty after reset", 32'(q_empty), 32'hF);
        cns_valid = 1; cns_explicit = 0; cns_reg = 3'd5;
        #1;
        check("R1 storage cleared", 32'(cns_data), 32'h0);
        cns_reg = 3'd6;
        #1;
        check("R1 binding cleared", 32'(cns_stall), 32'h0);
        @(negedge clk);
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule